// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It has a base table of 2-bit counters, indexed by branch address bits only. Above it sit four partially tagged tables. Each tagged table is indexed and tagged by a hash of the address, a prefix of the global outcome history and a short path history. The four history prefixes grow geometrically: 5, 9, 17 and 33 outcomes. All five tables are read together. The tagged table that matches and uses the longest history provides the prediction. When no tagged table matches, the base table decides.

The front end presents a branch address on the lookup port and reads the direction and its source in the same cycle. When the branch resolves, the back end presents the same address and the real outcome on the update port. In that clock edge the block does four things:
- It trains the table that provided the prediction.
- It adjusts that entry's usefulness.
- On a wrong prediction, it claims an entry in a table with a longer history.
- It shifts the outcome and one address bit into the histories.

Only one branch is in flight at a time. The update therefore sees the same history that the lookup saw.

Top module: `tgp_predictor`

## Requirements
- R1: With no tagged hit, the prediction comes from the base table. The base table has 256 two-bit counters indexed by pc[9:2]. It predicts taken when the counter is 2 or 3, and pred_src is then 0.
- R2: Tagged table k (k=1..4) uses history length L = 5, 9, 17, 33. H is the low L bits of the global history, bit 0 being the newest outcome. fold(x,n,w) XORs every bit i<n of x into result bit i mod w. The index is pc[7:2]^pc[13:8]^fold(H,L,6)^fold(P,8,6), where P is the path history. The tag is (pc[9:2]^fold(H,L,8)^(fold(H,L,7)<<1)) mod 256. An entry hits when its stored tag equals the computed tag.
- R3: The hitting table with the largest k is the provider, and pred_src equals k. Its 3-bit two's-complement counter predicts taken when it is 0 or more. The outputs follow lk_pc in the same cycle.
- R4: On update, the provider's counter saturates one step toward the outcome. Tagged counters range from -4 to 3. When the base table provides, its counter ranges from 0 to 3.
- R5: The alternate prediction comes from the next-lower hitting tagged table, or from the base table when there is none. If the provider is tagged and its prediction differs from the alternate, its 2-bit useful counter saturates up when the provider was right and down when it was wrong.
- R6: On a misprediction, the smallest table k above the provider whose useful counter at its update index is 0 receives a new entry. The entry gets the computed tag, counter 0 for taken or -1 for not-taken, and useful 0. At most one table allocates.
- R7: On a misprediction with a provider below 4 and no free candidate, every table above the provider decrements its useful counter, saturating at 0. Nothing is allocated.
- R8: On update, the global history shifts in the outcome and the 8-bit path history shifts in pc[2]. Without up_valid, no state changes.
- R9: After reset:
  - every tagged counter is -1;
  - every useful counter and tag is 0;
  - every base counter is 1;
  - both histories are 0.

  Every lookup then predicts not-taken.
- R10: One branch address that repeats taken, taken, taken, not-taken is mispredicted at most 8 times in 200 consecutive branches after 400 warm-up branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_src | output | 3 | Provider: 0 = base table, k = tagged table k |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The assertions assume that reset is applied before the first branch and that up_taken is a known value whenever up_valid is high. They also assume that the update for a branch follows its lookup with no other update in between, so that both see the same history. The stimulus changes every input on the falling clock edge. It always looks up an address before sending that same address with its outcome for one cycle. It never issues two updates back to back without a lookup between them.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  localparam int PC_W    = 32;
  localparam int NTAB    = 4;
  localparam int IDX_W   = 6;
  localparam int TAG_W   = 8;
  localparam int CTR_W   = 3;
  localparam int U_W     = 2;
  localparam int BIDX_W  = 8;
  localparam int BCTR_W  = 2;
  localparam int PH_W    = 8;
  localparam int SRC_W   = $clog2(NTAB + 1);
  localparam int FOLD_W  = 8;
  localparam int HBUF_W  = 64;

  // geometric history length for table k: 2^(k+1)+1
  function automatic int hist_len(input int k);
    return (1 << (k + 1)) + 1;
  endfunction

  localparam int GH_W = hist_len(NTAB);

  function automatic logic [FOLD_W-1:0] fold(input logic [HBUF_W-1:0] h,
                                            input int n, input int w);
    logic [FOLD_W-1:0] r;
    r = '0;
    for (int i = 0; i < HBUF_W; i++)
      if (i < n) r[i % w] = r[i % w] ^ h[i];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] tbl_index(input logic [PC_W-1:0] pc,
      input logic [HBUF_W-1:0] gh, input logic [PH_W-1:0] ph, input int len);
    logic [FOLD_W-1:0] fh, fp;
    fh = fold(gh, len, IDX_W);
    fp = fold({{(HBUF_W-PH_W){1'b0}}, ph}, PH_W, IDX_W);
    return pc[2 +: IDX_W] ^ pc[2+IDX_W +: IDX_W] ^ fh[IDX_W-1:0] ^ fp[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tbl_tag(input logic [PC_W-1:0] pc,
      input logic [HBUF_W-1:0] gh, input int len);
    logic [FOLD_W-1:0] f1, f2;
    f1 = fold(gh, len, TAG_W);
    f2 = fold(gh, len, TAG_W - 1);
    return pc[2 +: TAG_W] ^ f1[TAG_W-1:0] ^ {f2[TAG_W-2:0], 1'b0};
  endfunction

  function automatic logic [BIDX_W-1:0] base_index(input logic [PC_W-1:0] pc);
    return pc[2 +: BIDX_W];
  endfunction

  // signed saturating step
  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c,
                                               input logic up);
    if (up)  return (c == {1'b0, {(CTR_W-1){1'b1}}}) ? c : c + 1'b1;
    else     return (c == {1'b1, {(CTR_W-1){1'b0}}}) ? c : c - 1'b1;
  endfunction

  function automatic logic [BCTR_W-1:0] bctr_step(input logic [BCTR_W-1:0] c,
                                                 input logic up);
    if (up)  return (&c) ? c : c + 1'b1;
    else     return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic [U_W-1:0] u_step(input logic [U_W-1:0] u,
                                           input logic up);
    if (up)  return (&u) ? u : u + 1'b1;
    else     return (u == '0) ? u : u - 1'b1;
  endfunction
endpackage

// File: rtl/tgp_history.sv
module tgp_history
  import tgp_pkg::*;
#(
  parameter int GHW = GH_W,
  parameter int PHW = PH_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           up_valid,
  input  logic           up_taken,
  input  logic           up_pc_bit,
  output logic [GHW-1:0] ghist,
  output logic [PHW-1:0] phist
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      phist <= '0;
    end else if (up_valid) begin
      ghist <= {ghist[GHW-2:0], up_taken};
      phist <= {phist[PHW-2:0], up_pc_bit};
    end
  end

  AST_GH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist[0] == $past(up_taken));  // R8
  AST_GH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist) && $stable(phist));  // R8
endmodule

// File: rtl/tgp_base_table.sv
module tgp_base_table
  import tgp_pkg::*;
#(
  parameter int IW = BIDX_W,
  parameter int CW = BCTR_W,
  localparam int DEPTH = 1 << IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [PC_W-1:0] up_pc,
  output logic            lk_taken,
  output logic            up_pred,
  input  logic            wr_en,
  input  logic            wr_taken
);
  logic [CW-1:0] ctr_q [DEPTH];
  logic [IW-1:0] lk_idx, up_idx;

  assign lk_idx   = base_index(lk_pc);
  assign up_idx   = base_index(up_pc);
  assign lk_taken = ctr_q[lk_idx][CW-1];
  assign up_pred  = ctr_q[up_idx][CW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= CW'(1);
    end else if (wr_en) begin
      ctr_q[up_idx] <= bctr_step(ctr_q[up_idx], wr_taken);
    end
  end
endmodule

// File: rtl/tgp_tagged_table.sv
module tgp_tagged_table
  import tgp_pkg::*;
#(
  parameter int HLEN = 5,
  parameter int GHW  = GH_W,
  parameter int IW   = IDX_W,
  localparam int DEPTH = 1 << IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [GHW-1:0]   ghist,
  input  logic [PH_W-1:0]  phist,
  output logic             lk_hit,
  output logic [CTR_W-1:0] lk_ctr,
  output logic             up_hit,
  output logic [CTR_W-1:0] up_ctr,
  output logic [U_W-1:0]   up_u,
  input  logic             wr_ctr_en,
  input  logic [CTR_W-1:0] wr_ctr_val,
  input  logic             wr_u_en,
  input  logic [U_W-1:0]   wr_u_val,
  input  logic             wr_alloc,
  input  logic             wr_alloc_taken
);
  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [U_W-1:0]   u_q   [DEPTH];

  logic [HBUF_W-1:0] gh_ext;
  logic [IW-1:0]     lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;

  assign gh_ext = {{(HBUF_W-GHW){1'b0}}, ghist};
  assign lk_idx = tbl_index(lk_pc, gh_ext, phist, HLEN);
  assign up_idx = tbl_index(up_pc, gh_ext, phist, HLEN);
  assign lk_tag = tbl_tag(lk_pc, gh_ext, HLEN);
  assign up_tag = tbl_tag(up_pc, gh_ext, HLEN);

  assign lk_hit = (tag_q[lk_idx] == lk_tag);
  assign lk_ctr = ctr_q[lk_idx];
  assign up_hit = (tag_q[up_idx] == up_tag);
  assign up_ctr = ctr_q[up_idx];
  assign up_u   = u_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        ctr_q[e] <= '1;
        tag_q[e] <= '0;
        u_q[e]   <= '0;
      end
    end else if (wr_alloc) begin
      tag_q[up_idx] <= up_tag;
      ctr_q[up_idx] <= wr_alloc_taken ? '0 : '1;
      u_q[up_idx]   <= '0;
    end else begin
      if (wr_ctr_en) ctr_q[up_idx] <= wr_ctr_val;
      if (wr_u_en)   u_q[up_idx]   <= wr_u_val;
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alloc |-> (up_u == '0));  // R6
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alloc |-> !(wr_ctr_en || wr_u_en));  // R7
endmodule

// File: rtl/tgp_predictor.sv
module tgp_predictor
  import tgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_taken,
  output logic [SRC_W-1:0]  pred_src,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken
);
  logic [GH_W-1:0] ghist;
  logic [PH_W-1:0] phist;

  logic [NTAB:1]    lk_hit, up_hit;
  logic [CTR_W-1:0] lk_ctr [1:NTAB];
  logic [CTR_W-1:0] up_ctr [1:NTAB];
  logic [U_W-1:0]   up_u   [1:NTAB];
  logic [NTAB:0]    lk_tpred, up_tpred;

  logic [NTAB:1]    wr_ctr_en, wr_u_en, alloc_vec, decay_vec, cand_vec;
  logic [CTR_W-1:0] wr_ctr_val [1:NTAB];
  logic [U_W-1:0]   wr_u_val   [1:NTAB];

  logic [SRC_W-1:0] lk_prov, up_prov, up_alt;
  logic             prov_pred, alt_pred, mispred, no_free, base_wr;

  tgp_history u_hist (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
    .up_pc_bit(up_pc[2]), .ghist(ghist), .phist(phist)
  );

  tgp_base_table u_base (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_pc(up_pc),
    .lk_taken(lk_tpred[0]), .up_pred(up_tpred[0]),
    .wr_en(base_wr), .wr_taken(up_taken)
  );

  for (genvar k = 1; k <= NTAB; k++) begin : g_tbl
    tgp_tagged_table #(.HLEN(hist_len(k))) u_tbl (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_pc(up_pc),
      .ghist(ghist), .phist(phist),
      .lk_hit(lk_hit[k]), .lk_ctr(lk_ctr[k]),
      .up_hit(up_hit[k]), .up_ctr(up_ctr[k]), .up_u(up_u[k]),
      .wr_ctr_en(wr_ctr_en[k]), .wr_ctr_val(wr_ctr_val[k]),
      .wr_u_en(wr_u_en[k]), .wr_u_val(wr_u_val[k]),
      .wr_alloc(alloc_vec[k]), .wr_alloc_taken(up_taken)
    );

    assign lk_tpred[k] = ~lk_ctr[k][CTR_W-1];
    assign up_tpred[k] = ~up_ctr[k][CTR_W-1];
    assign cand_vec[k] = (up_prov < SRC_W'(k)) && (up_u[k] == '0);
    assign decay_vec[k] = up_valid && mispred && no_free && (up_prov < SRC_W'(k));
    assign wr_ctr_en[k] = up_valid && (up_prov == SRC_W'(k));
    assign wr_ctr_val[k] = ctr_step(up_ctr[k], up_taken);
    assign wr_u_en[k] = decay_vec[k] ||
                        (up_valid && (up_prov == SRC_W'(k)) && (prov_pred != alt_pred));
    assign wr_u_val[k] = u_step(up_u[k], !decay_vec[k] && (prov_pred == up_taken));

    AST_ALLOC_LONGER: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vec[k] |-> (up_prov < SRC_W'(k)));  // R6
  end

  // provider selection: highest hitting table wins
  always_comb begin
    lk_prov = '0;
    up_prov = '0;
    for (int k = 1; k <= NTAB; k++) begin
      if (lk_hit[k]) lk_prov = SRC_W'(k);
      if (up_hit[k]) up_prov = SRC_W'(k);
    end
    up_alt = '0;
    for (int k = 1; k <= NTAB; k++)
      if (up_hit[k] && (SRC_W'(k) < up_prov)) up_alt = SRC_W'(k);
  end

  assign pred_src   = lk_prov;
  assign pred_taken = lk_tpred[lk_prov];
  assign prov_pred  = up_tpred[up_prov];
  assign alt_pred   = up_tpred[up_alt];
  assign mispred    = (prov_pred != up_taken);
  assign no_free    = (cand_vec == '0);
  assign base_wr    = up_valid && (up_prov == '0);

  // allocation: lowest free table above the provider
  always_comb begin
    alloc_vec = '0;
    if (up_valid && mispred) begin
      for (int k = NTAB; k >= 1; k--)
        if (cand_vec[k]) begin
          alloc_vec = '0;
          alloc_vec[k] = 1'b1;
        end
    end
  end

  AST_BASE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit == '0) |-> (pred_taken == lk_tpred[0]) && (pred_src == '0));  // R1
  AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));  // R6
  AST_ALLOC_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vec != '0) |-> (up_valid && mispred));  // R6
  AST_DECAY_XOR_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    !((alloc_vec != '0) && (decay_vec != '0)));  // R7
endmodule

// File: tb/tgp_predictor_tb.sv
module tgp_predictor_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic        pred_taken;
  logic [2:0]  pred_src;
  logic        up_valid = 0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  tgp_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_src(pred_src), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  // ---------------- reference model ----------------
  int        m_ctr [1:4][64];
  int        m_tag [1:4][64];
  int        m_u   [1:4][64];
  int        m_base[256];
  bit [63:0] m_gh;
  bit [7:0]  m_ph;
  int        m_len [1:4] = '{5, 9, 17, 33};

  function automatic int cfold(bit [63:0] x, int n, int w);
    int r = 0;
    bit [63:0] h = (n >= 64) ? x : (x & ((64'd1 << n) - 1));
    for (int c = 0; c * w < n; c++) r = r ^ int'((h >> (c * w)) & ((64'd1 << w) - 1));
    return r;
  endfunction

  function automatic int m_idx(bit [31:0] pc, int k);
    return int'(pc[7:2]) ^ int'(pc[13:8]) ^ cfold(m_gh, m_len[k], 6) ^ cfold(64'(m_ph), 8, 6);
  endfunction

  function automatic int m_tg(bit [31:0] pc, int k);
    return (int'(pc[9:2]) ^ cfold(m_gh, m_len[k], 8) ^ (cfold(m_gh, m_len[k], 7) << 1)) & 255;
  endfunction

  function automatic void m_reset();
    for (int k = 1; k <= 4; k++)
      for (int e = 0; e < 64; e++) begin m_ctr[k][e] = -1; m_tag[k][e] = 0; m_u[k][e] = 0; end
    for (int e = 0; e < 256; e++) m_base[e] = 1;
    m_gh = '0; m_ph = '0;
  endfunction

  function automatic void m_predict(bit [31:0] pc, output bit p, output int src);
    src = 0;
    p = m_base[pc[9:2]] >= 2;
    for (int k = 1; k <= 4; k++)
      if (m_tag[k][m_idx(pc, k)] == m_tg(pc, k)) begin src = k; p = m_ctr[k][m_idx(pc, k)] >= 0; end
  endfunction

  function automatic void m_update(bit [31:0] pc, bit t);
    int idx[1:4]; bit hit[1:4]; int prov = 0, alt = 0; bit pp, ap, anyfree = 0; int first = 0;
    for (int k = 1; k <= 4; k++) begin
      idx[k] = m_idx(pc, k);
      hit[k] = m_tag[k][idx[k]] == m_tg(pc, k);
      if (hit[k]) begin alt = prov; prov = k; end
    end
    pp = prov == 0 ? (m_base[pc[9:2]] >= 2) : (m_ctr[prov][idx[prov]] >= 0);
    ap = alt == 0 ? (m_base[pc[9:2]] >= 2) : (m_ctr[alt][idx[alt]] >= 0);
    if (prov == 0) begin
      if (t && m_base[pc[9:2]] < 3) m_base[pc[9:2]]++;
      if (!t && m_base[pc[9:2]] > 0) m_base[pc[9:2]]--;
    end else begin
      if (t && m_ctr[prov][idx[prov]] < 3) m_ctr[prov][idx[prov]]++;
      if (!t && m_ctr[prov][idx[prov]] > -4) m_ctr[prov][idx[prov]]--;
      if (pp != ap) begin
        if (pp == t && m_u[prov][idx[prov]] < 3) m_u[prov][idx[prov]]++;
        if (pp != t && m_u[prov][idx[prov]] > 0) m_u[prov][idx[prov]]--;
      end
    end
    if (pp != t) begin
      for (int k = 4; k > prov; k--) if (m_u[k][idx[k]] == 0) begin anyfree = 1; first = k; end
      if (anyfree) begin
        m_tag[first][idx[first]] = m_tg(pc, first);
        m_ctr[first][idx[first]] = t ? 0 : -1;
        m_u[first][idx[first]] = 0;
      end else
        for (int k = prov + 1; k <= 4; k++) if (m_u[k][idx[k]] > 0) m_u[k][idx[k]]--;
    end
    m_gh = {m_gh[62:0], t};
    m_ph = {m_ph[6:0], pc[2]};
  endfunction

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one branch: lookup, compare, then resolve; returns whether DUT mispredicted
  task automatic branch(bit [31:0] pc, bit t, string req, output bit miss);
    bit ep; int es;
    @(negedge clk);
    lk_pc = pc; up_valid = 0;
    #1;
    m_predict(pc, ep, es);
    check(pred_taken == ep, req, "pred_taken", int'(pred_taken), int'(ep));
    check(int'(pred_src) == es, req, "pred_src", int'(pred_src), es);
    miss = pred_taken != t;
    up_pc = pc; up_taken = t; up_valid = 1;
    m_update(pc, t);
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; up_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); lk_pc = 32'h1000 + 32'(i * 52); #1;
      check(pred_taken == 0, "R9", "reset pred", int'(pred_taken), 0);
    end
  endtask

  task automatic t_base_train();
    bit m;
    // R1 R4: training one address taken flips base then tagged tables
    for (int i = 0; i < 12; i++) branch(32'h0000_0440, 1, "R1 R4 R6", m);
    for (int i = 0; i < 12; i++) branch(32'h0000_0440, 0, "R4 R5 R7", m);
  endtask

  task automatic t_hold();
    bit p0; logic [2:0] s0; bit m;
    branch(32'h0000_2a0c, 1, "R8", m);
    @(negedge clk); lk_pc = 32'h0000_2a0c; #1; p0 = pred_taken; s0 = pred_src;
    for (int i = 0; i < 4; i++) begin @(negedge clk); lk_pc = 32'h0000_7000 + 32'(i * 4); end
    @(negedge clk); lk_pc = 32'h0000_2a0c; #1;
    check(pred_taken == p0, "R8", "no-update pred", int'(pred_taken), int'(p0));
    check(pred_src == s0, "R8", "no-update src", int'(pred_src), int'(s0));
  endtask

  task automatic t_two_pc();
    bit m;
    do_reset();
    for (int i = 0; i < 150; i++) begin
      branch(32'h0000_1180, i[0], "R2 R3", m);
      branch(32'h0000_3394, 1, "R2 R3", m);
    end
  endtask

  task automatic t_pattern();
    bit m; int misses = 0;
    do_reset();
    for (int i = 0; i < 600; i++) begin
      branch(32'h0000_0a5c, (i % 4) != 3, "R2 R3 R5 R6", m);
      if (i >= 400 && m) misses++;
    end
    check(misses <= 8, "R10", "late mispredictions", misses, 8);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_base_train();
    t_hold();
    t_two_pc();
    t_pattern();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule